// File: doc/BRIEF.md
# VT Remote Indication Bit Generator

This block builds the return-path remote indication bits for up to 28 virtual tributaries. For each tributary it produces the error indication (REI-V), the failure indication (RFI-V) and the one-bit defect indication (RDI-V) carried in V5 bit 8. When a tributary runs in enhanced mode, it also produces the three-bit enhanced defect code carried in Z7 bits 5 to 7. Each bit has its own source. A software-written manual value wins first. Next comes the value copied from received lower-order overhead storage, used when ring-protection insertion is on for that channel. Last comes an automatic value built from the local defect flags and BIP-2 error pulses. REI has no manual source.

Channels are serviced one at a time. A 5-bit index (1 to 28) arrives with that channel's defect flags, BIP-2 error pulse, stored received overhead and a multiframe boundary flag. Each channel has a two-state BIP tracker. It moves from BIP_CLEAN to BIP_ERRORED when an error pulse arrives on a non-boundary service cycle. It moves from BIP_ERRORED back to BIP_CLEAN on that channel's boundary cycle. On a boundary cycle the block resolves each bit's source to SRC_MANUAL, SRC_RING or SRC_AUTO. For the enhanced code it also classifies the defects as ERDI_NONE, ERDI_PAYLOAD, ERDI_SERVER or ERDI_CONN. It then registers the result, which appears on the outputs one cycle later. Between boundaries the outputs hold their value. Per-channel control words are written through a one-cycle write port.

Top module: `rvi_gen`

## Requirements
- R1: A service or control write whose channel index is 0 or above 28 changes no state and produces no output strobe; a strobe carries in out_ch the index of the service cycle that caused it.
- R2: Control word bits: [0] ring insertion, [1] REI enable, [2] RFI manual, [3] RFI value, [4] RDI manual, [5] RDI value, [6] enhanced mode, [7] enhanced manual, [10:8] enhanced value (bit 10 maps to Z7 bit 5), [11] byte-synchronous; a write takes effect from the next cycle.
- R3: REI-V equals the stored received REI when ring insertion and REI enable are both set; it equals the channel's BIP error flag when only REI enable is set; otherwise it is 0.
- R4: The BIP error flag is set if any error pulse arrived on that channel's service cycles since its last boundary, the boundary cycle included; each boundary clears it.
- R5: RFI-V equals the RFI value bit when RFI manual is set; otherwise the stored received RFI when ring insertion is set; otherwise the automatic value.
- R6: Automatic RFI-V is 1 on AIS-V, LOP-V, UNEQ-V or TIM-V, and also on the framer RAI input when the channel is byte-synchronous; defect input bits are [0] AIS, [1] LOP, [2] UNEQ, [3] PLM, [4] TIM.
- R7: In one-bit mode RDI-V follows the RDI value bit when RDI manual is set, otherwise the stored received RDI when ring insertion is set, otherwise 1 on AIS-V, LOP-V, UNEQ-V, PLM-V or upstream automatic AIS.
- R8: In one-bit mode the Z7 field output is 000.
- R9: The automatic enhanced code (Z7 bits 5,6,7) is 101 for AIS-V or LOP-V, else 110 for UNEQ-V or TIM-V, else 010 for PLM-V, else 001.
- R10: In enhanced mode the Z7 field takes the enhanced value when enhanced manual is set, otherwise the stored received code (received overhead bits [5:3]; [0] REI, [1] RFI, [2] RDI) when ring insertion is set, otherwise the automatic code; V5 bit 8 then equals Z7 bit 5.
- R11: Outputs and the strobe change only one cycle after a valid boundary service cycle and hold otherwise.
- R12: After reset all outputs are 0 and every channel's control word and error flag are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_ch | input | 5 | Channel index of the write |
| cfg_wdata | input | 12 | Control word |
| svc_vld | input | 1 | Service cycle valid |
| svc_ch | input | 5 | Channel index being serviced |
| svc_mf | input | 1 | Multiframe boundary for this channel |
| svc_def | input | 5 | Defect flags of the channel |
| svc_auto_ais | input | 1 | Automatic AIS from upstream pointer processing |
| svc_rai | input | 1 | Remote alarm from the attached DS1 framer |
| svc_bip_err | input | 1 | BIP-2 error pulse for the channel |
| svc_rx_oh | input | 6 | Stored received overhead bits of the channel |
| out_vld | output | 1 | One-cycle strobe when new bits are presented |
| out_ch | output | 5 | Channel of the presented bits |
| out_rei | output | 1 | REI-V |
| out_rfi | output | 1 | RFI-V |
| out_rdi | output | 1 | V5 bit 8 |
| out_z7 | output | 3 | Z7 bits 5,6,7 (MSB is bit 5) |

## Verification
The assertions assume that every input is driven to a known value on every clock. They also assume that the service index is sampled only together with svc_vld, so a strobe can be traced back to the cycle before it. The stimulus sets every input to a definite value at each falling edge, including indices 0, 29 and 31. It mixes boundary and non-boundary cycles, so the hold and strobe properties are exercised in both directions.

// File: rtl/rvi_pkg.sv
package rvi_pkg;

    typedef struct packed {
        logic       bsync;
        logic [2:0] erdi_val;
        logic       erdi_man;
        logic       erdi_sel;
        logic       rdi_val;
        logic       rdi_man;
        logic       rfi_val;
        logic       rfi_man;
        logic       rei_en;
        logic       upsr;
    } ch_cfg_t;

    typedef struct packed {
        logic tim;
        logic plm;
        logic uneq;
        logic lop;
        logic ais;
    } defect_t;

    typedef struct packed {
        logic [2:0] erdi;
        logic       rdi;
        logic       rfi;
        logic       rei;
    } rx_oh_t;

    typedef enum logic {
        BIP_CLEAN,
        BIP_ERRORED
    } bip_st_t;

    typedef enum logic [1:0] {
        SRC_MANUAL,
        SRC_RING,
        SRC_AUTO
    } src_t;

    typedef enum logic [1:0] {
        ERDI_NONE,
        ERDI_PAYLOAD,
        ERDI_SERVER,
        ERDI_CONN
    } erdi_cls_t;

    localparam logic [2:0] Z7_NONE    = 3'b001;
    localparam logic [2:0] Z7_PAYLOAD = 3'b010;
    localparam logic [2:0] Z7_SERVER  = 3'b101;
    localparam logic [2:0] Z7_CONN    = 3'b110;

    function automatic src_t pick_src(input logic man, input logic ring);
        if (man)
            return SRC_MANUAL;
        else if (ring)
            return SRC_RING;
        else
            return SRC_AUTO;
    endfunction

endpackage

// File: rtl/rvi_cfg_bank.sv
module rvi_cfg_bank
    import rvi_pkg::*;
#(
    parameter int NCH = 28,
    parameter int CHW = $clog2(NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_ch,
    input  ch_cfg_t        wr_data,
    input  logic [CHW-1:0] rd_ch,
    output ch_cfg_t        rd_cfg
);

    ch_cfg_t bank [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [CHW-1:0] MY_CH = CHW'(g + 1);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank[g] <= '0;
            else if (wr_en && wr_ch == MY_CH)
                bank[g] <= wr_data;
        end
    end

    always_comb begin
        rd_cfg = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_ch == CHW'(i + 1))
                rd_cfg = bank[i];
        end
    end

endmodule

// File: rtl/rvi_bip_track.sv
module rvi_bip_track
    import rvi_pkg::*;
#(
    parameter int NCH = 28,
    parameter int CHW = $clog2(NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           svc_vld,
    input  logic [CHW-1:0] svc_ch,
    input  logic           svc_mf,
    input  logic           bip_err,
    output logic           err_seen
);

    logic [NCH-1:0] errored;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [CHW-1:0] MY_CH = CHW'(g + 1);
        bip_st_t st, st_nxt;
        logic    hit;

        assign hit = svc_vld && (svc_ch == MY_CH);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                st <= BIP_CLEAN;
            else
                st <= st_nxt;
        end

        always_comb begin
            st_nxt = st;
            unique case (st)
                BIP_CLEAN:   if (hit && !svc_mf && bip_err) st_nxt = BIP_ERRORED;
                BIP_ERRORED: if (hit && svc_mf)             st_nxt = BIP_CLEAN;
            endcase
        end

        assign errored[g] = (st == BIP_ERRORED);
    end

    always_comb begin
        err_seen = bip_err;
        for (int i = 0; i < NCH; i++) begin
            if (svc_ch == CHW'(i + 1) && errored[i])
                err_seen = 1'b1;
        end
    end

endmodule

// File: rtl/rvi_ind_encode.sv
module rvi_ind_encode
    import rvi_pkg::*;
(
    input  ch_cfg_t    cfg,
    input  defect_t    def,
    input  logic       auto_ais,
    input  logic       rai,
    input  logic       err_seen,
    input  rx_oh_t     rx,
    output logic       rei,
    output logic       rfi,
    output logic       rdi,
    output logic [2:0] z7
);

    logic      auto_rfi;
    logic      auto_rdi;
    logic      bit_rdi;
    logic [2:0] auto_z7;
    logic [2:0] erdi_code;
    erdi_cls_t cls;

    always_comb begin
        auto_rfi = def.ais | def.lop | def.uneq | def.tim | (cfg.bsync & rai);
        auto_rdi = def.ais | def.lop | def.uneq | def.plm | auto_ais;

        if (def.ais || def.lop)
            cls = ERDI_SERVER;
        else if (def.uneq || def.tim)
            cls = ERDI_CONN;
        else if (def.plm)
            cls = ERDI_PAYLOAD;
        else
            cls = ERDI_NONE;

        unique case (cls)
            ERDI_NONE:    auto_z7 = Z7_NONE;
            ERDI_PAYLOAD: auto_z7 = Z7_PAYLOAD;
            ERDI_SERVER:  auto_z7 = Z7_SERVER;
            ERDI_CONN:    auto_z7 = Z7_CONN;
        endcase
    end

    always_comb begin
        unique case (pick_src(1'b0, cfg.upsr))
            SRC_MANUAL: rei = 1'b0;
            SRC_RING:   rei = cfg.rei_en & rx.rei;
            SRC_AUTO:   rei = cfg.rei_en & err_seen;
            default:    rei = 1'b0;
        endcase

        unique case (pick_src(cfg.rfi_man, cfg.upsr))
            SRC_MANUAL: rfi = cfg.rfi_val;
            SRC_RING:   rfi = rx.rfi;
            SRC_AUTO:   rfi = auto_rfi;
            default:    rfi = 1'b0;
        endcase

        unique case (pick_src(cfg.rdi_man, cfg.upsr))
            SRC_MANUAL: bit_rdi = cfg.rdi_val;
            SRC_RING:   bit_rdi = rx.rdi;
            SRC_AUTO:   bit_rdi = auto_rdi;
            default:    bit_rdi = 1'b0;
        endcase

        unique case (pick_src(cfg.erdi_man, cfg.upsr))
            SRC_MANUAL: erdi_code = cfg.erdi_val;
            SRC_RING:   erdi_code = rx.erdi;
            SRC_AUTO:   erdi_code = auto_z7;
            default:    erdi_code = 3'b000;
        endcase

        if (cfg.erdi_sel) begin
            z7  = erdi_code;
            rdi = erdi_code[2];
        end else begin
            z7  = 3'b000;
            rdi = bit_rdi;
        end
    end

endmodule

// File: rtl/rvi_gen.sv
module rvi_gen
    import rvi_pkg::*;
#(
    parameter int NCH = 28,
    parameter int CHW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [11:0]    cfg_wdata,
    input  logic           svc_vld,
    input  logic [CHW-1:0] svc_ch,
    input  logic           svc_mf,
    input  logic [4:0]     svc_def,
    input  logic           svc_auto_ais,
    input  logic           svc_rai,
    input  logic           svc_bip_err,
    input  logic [5:0]     svc_rx_oh,
    output logic           out_vld,
    output logic [CHW-1:0] out_ch,
    output logic           out_rei,
    output logic           out_rfi,
    output logic           out_rdi,
    output logic [2:0]     out_z7
);

    localparam logic [CHW-1:0] CH_MAX = CHW'(NCH);

    logic    svc_ok;
    logic    cfg_ok;
    ch_cfg_t cur_cfg;
    logic    err_seen;
    logic    n_rei, n_rfi, n_rdi;
    logic [2:0] n_z7;

    assign svc_ok = svc_vld && (svc_ch != '0) && (svc_ch <= CH_MAX);
    assign cfg_ok = cfg_we && (cfg_ch != '0) && (cfg_ch <= CH_MAX);

    rvi_cfg_bank #(.NCH(NCH), .CHW(CHW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_ok),
        .wr_ch   (cfg_ch),
        .wr_data (ch_cfg_t'(cfg_wdata)),
        .rd_ch   (svc_ch),
        .rd_cfg  (cur_cfg)
    );

    rvi_bip_track #(.NCH(NCH), .CHW(CHW)) u_bip (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_vld  (svc_ok),
        .svc_ch   (svc_ch),
        .svc_mf   (svc_mf),
        .bip_err  (svc_bip_err),
        .err_seen (err_seen)
    );

    rvi_ind_encode u_enc (
        .cfg      (cur_cfg),
        .def      (defect_t'(svc_def)),
        .auto_ais (svc_auto_ais),
        .rai      (svc_rai),
        .err_seen (err_seen),
        .rx       (rx_oh_t'(svc_rx_oh)),
        .rei      (n_rei),
        .rfi      (n_rfi),
        .rdi      (n_rdi),
        .z7       (n_z7)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_ch  <= '0;
            out_rei <= 1'b0;
            out_rfi <= 1'b0;
            out_rdi <= 1'b0;
            out_z7  <= 3'b000;
        end else begin
            out_vld <= svc_ok && svc_mf;
            if (svc_ok && svc_mf) begin
                out_ch  <= svc_ch;
                out_rei <= n_rei;
                out_rfi <= n_rfi;
                out_rdi <= n_rdi;
                out_z7  <= n_z7;
            end
        end
    end

endmodule

// File: rtl/rvi_gen_chk.sv
module rvi_gen_chk #(
    parameter int NCH = 28,
    parameter int CHW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           svc_vld,
    input logic [CHW-1:0] svc_ch,
    input logic           svc_mf,
    input logic           out_vld,
    input logic [CHW-1:0] out_ch,
    input logic           out_rei,
    input logic           out_rfi,
    input logic           out_rdi,
    input logic [2:0]     out_z7
);

    logic ch_in_range;
    assign ch_in_range = (svc_ch != '0) && (int'(svc_ch) <= NCH);

    AST_STROBE_FROM_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(svc_vld && svc_mf && ch_in_range)); // R11

    AST_NO_STROBE_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        svc_vld && !svc_mf |=> !out_vld); // R11

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable({out_ch, out_rei, out_rfi, out_rdi, out_z7})); // R11

    AST_BADCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        svc_vld && !ch_in_range |=> !out_vld); // R1

    AST_CH_TRACKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> out_ch == $past(svc_ch)); // R1

    AST_V5_MIRRORS_Z7: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && out_z7 != 3'b000 |-> out_rdi == out_z7[2]); // R10

endmodule

bind rvi_gen rvi_gen_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .svc_vld (svc_vld),
    .svc_ch  (svc_ch),
    .svc_mf  (svc_mf),
    .out_vld (out_vld),
    .out_ch  (out_ch),
    .out_rei (out_rei),
    .out_rfi (out_rfi),
    .out_rdi (out_rdi),
    .out_z7  (out_z7)
);

// File: tb/rvi_gen_test.sv
module rvi_gen_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_ch = '0;
    logic [11:0] cfg_wdata = '0;
    logic       svc_vld = 1'b0;
    logic [4:0] svc_ch = '0;
    logic       svc_mf = 1'b0;
    logic [4:0] svc_def = '0;
    logic       svc_auto_ais = 1'b0;
    logic       svc_rai = 1'b0;
    logic       svc_bip_err = 1'b0;
    logic [5:0] svc_rx_oh = '0;
    logic       out_vld;
    logic [4:0] out_ch;
    logic       out_rei, out_rfi, out_rdi;
    logic [2:0] out_z7;

    int nvec = 0;
    int nbad = 0;

    // reference state
    logic [11:0] m_cfg [1:28];
    bit          m_err [1:28];
    bit          e_vld = 0;
    int          e_ch = 0, e_rei = 0, e_rfi = 0, e_rdi = 0, e_z7 = 0;

    always #(CLK_P/2) clk = ~clk;

    rvi_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata),
        .svc_vld(svc_vld), .svc_ch(svc_ch), .svc_mf(svc_mf), .svc_def(svc_def),
        .svc_auto_ais(svc_auto_ais), .svc_rai(svc_rai), .svc_bip_err(svc_bip_err),
        .svc_rx_oh(svc_rx_oh), .out_vld(out_vld), .out_ch(out_ch), .out_rei(out_rei),
        .out_rfi(out_rfi), .out_rdi(out_rdi), .out_z7(out_z7)
    );

    task automatic chk(input string tag, input int act, input int exp);
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pick(input bit man, input int manv, input bit ring, input int ringv, input int autov);
        if (man) return manv;
        if (ring) return ringv;
        return autov;
    endfunction

    task automatic tick();
        int  ch = svc_ch;
        bit  ok = svc_vld && ch >= 1 && ch <= 28;
        bit  ais = svc_def[0], lop = svc_def[1], uneq = svc_def[2], plm = svc_def[3], tim = svc_def[4];
        if (ok && svc_mf) begin
            logic [11:0] c = m_cfg[ch];
            bit err = m_err[ch] || svc_bip_err;
            int a_rfi, a_rdi, a_z7, code;
            a_rfi = (ais || lop || uneq || tim || (c[11] && svc_rai)) ? 1 : 0;
            a_rdi = (ais || lop || uneq || plm || svc_auto_ais) ? 1 : 0;
            if (ais || lop) a_z7 = 5;
            else if (uneq || tim) a_z7 = 6;
            else if (plm) a_z7 = 2;
            else a_z7 = 1;
            if (!c[1]) e_rei = 0;
            else if (c[0]) e_rei = svc_rx_oh[0];
            else e_rei = err;
            e_rfi = pick(c[2], c[3], c[0], svc_rx_oh[1], a_rfi);
            if (c[6]) begin
                code = pick(c[7], c[10:8], c[0], svc_rx_oh[5:3], a_z7);
                e_z7 = code;
                e_rdi = (code >> 2) & 1;
            end else begin
                e_z7 = 0;
                e_rdi = pick(c[4], c[5], c[0], svc_rx_oh[2], a_rdi);
            end
            e_ch = ch;
            e_vld = 1;
            m_err[ch] = 0;
        end else begin
            e_vld = 0;
            if (ok && svc_bip_err) m_err[ch] = 1;
        end
        if (cfg_we && cfg_ch >= 1 && cfg_ch <= 28) m_cfg[cfg_ch] = cfg_wdata;
        @(posedge clk);
        @(negedge clk);
        nvec++;
        chk("R1/R11 out_vld", out_vld, e_vld);
        chk("R1/R11 out_ch", out_ch, e_ch);
        chk("R3 out_rei", out_rei, e_rei);
        chk("R5 out_rfi", out_rfi, e_rfi);
        chk("R7 out_rdi", out_rdi, e_rdi);
        chk("R9 out_z7", out_z7, e_z7);
    endtask

    task automatic idle();
        cfg_we = 0; cfg_ch = 0; cfg_wdata = 0; svc_vld = 0; svc_ch = 0; svc_mf = 0;
        svc_def = 0; svc_auto_ais = 0; svc_rai = 0; svc_bip_err = 0; svc_rx_oh = 0;
    endtask

    task automatic wcfg(input int ch, input logic [11:0] d);
        idle();
        cfg_we = 1; cfg_ch = 5'(ch); cfg_wdata = d;
        tick();
        idle();
    endtask

    task automatic svc(input int ch, input bit mf, input logic [4:0] def, input bit aais,
                       input bit rai, input bit err, input logic [5:0] oh);
        idle();
        svc_vld = 1; svc_ch = 5'(ch); svc_mf = mf; svc_def = def; svc_auto_ais = aais;
        svc_rai = rai; svc_bip_err = err; svc_rx_oh = oh;
        tick();
        idle();
    endtask

    initial begin
        #(CLK_P * 200000);
        nbad++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        for (int i = 1; i <= 28; i++) begin m_cfg[i] = '0; m_err[i] = 0; end
        idle();
        repeat (3) @(negedge clk);
        // R12: reset state
        nvec++;
        chk("R12 reset outputs", {out_vld, out_ch, out_rei, out_rfi, out_rdi, out_z7}, 0);
        rst_n = 1;
        @(negedge clk);

        // R12: channel defaults clear -> no REI even with error
        svc(4, 0, 0, 0, 0, 1, 0);
        svc(4, 1, 0, 0, 0, 0, 0);
        chk("R12 cleared config rei", out_rei, 0);

        // R3 / R4: error accumulation and clear; R2 field [1]
        wcfg(3, 12'h002);
        svc(3, 0, 0, 0, 0, 1, 0);
        svc(3, 0, 0, 0, 0, 0, 0);
        svc(3, 1, 0, 0, 0, 0, 0);
        chk("R4 error held to boundary", out_rei, 1);
        svc(3, 1, 0, 0, 0, 0, 0);
        chk("R4 cleared at boundary", out_rei, 0);
        svc(3, 1, 0, 0, 0, 1, 0);
        chk("R4 boundary-cycle error counts", out_rei, 1);
        wcfg(3, 12'h003);
        svc(3, 1, 0, 0, 0, 1, 6'h01);
        chk("R3 ring REI", out_rei, 1);
        wcfg(3, 12'h001);
        svc(3, 1, 0, 0, 0, 1, 6'h01);
        chk("R3 ring without enable", out_rei, 0);

        // R5: RFI sources
        wcfg(7, 12'h00C);
        svc(7, 1, 0, 0, 0, 0, 0);
        chk("R5 manual RFI", out_rfi, 1);
        wcfg(7, 12'h005);
        svc(7, 1, 5'h1F, 0, 0, 0, 6'h00);
        chk("R5 manual beats defects", out_rfi, 0);
        wcfg(7, 12'h001);
        svc(7, 1, 0, 0, 0, 0, 6'h02);
        chk("R5 ring RFI", out_rfi, 1);
        wcfg(7, 12'h000);
        svc(7, 1, 5'h10, 0, 0, 0, 0);
        chk("R5 auto RFI on TIM", out_rfi, 1);
        svc(7, 1, 5'h08, 0, 0, 0, 0);
        chk("R5 PLM not in RFI", out_rfi, 0);

        // R6: RAI in byte-synchronous mode
        wcfg(8, 12'h800);
        svc(8, 1, 0, 0, 1, 0, 0);
        chk("R6 RAI byte-sync", out_rfi, 1);
        wcfg(8, 12'h000);
        svc(8, 1, 0, 0, 1, 0, 0);
        chk("R6 RAI ignored async", out_rfi, 0);

        // R7 / R8: one-bit RDI
        svc(10, 1, 0, 1, 0, 0, 0);
        chk("R7 auto AIS RDI", out_rdi, 1);
        chk("R8 one-bit Z7 zero", out_z7, 0);
        svc(10, 1, 5'h08, 0, 0, 0, 0);
        chk("R7 PLM RDI", out_rdi, 1);
        wcfg(10, 12'h010);
        svc(10, 1, 5'h01, 0, 0, 0, 0);
        chk("R7 manual RDI zero", out_rdi, 0);
        wcfg(10, 12'h001);
        svc(10, 1, 0, 0, 0, 0, 6'h04);
        chk("R7 ring RDI", out_rdi, 1);
        chk("R8 Z7 zero ring", out_z7, 0);

        // R9: enhanced codes and priority
        wcfg(12, 12'h040);
        svc(12, 1, 5'h00, 0, 0, 0, 0); chk("R9 none", out_z7, 1);
        svc(12, 1, 5'h08, 0, 0, 0, 0); chk("R9 PLM", out_z7, 2);
        svc(12, 1, 5'h09, 0, 0, 0, 0); chk("R9 AIS over PLM", out_z7, 5);
        svc(12, 1, 5'h0C, 0, 0, 0, 0); chk("R9 UNEQ over PLM", out_z7, 6);
        svc(12, 1, 5'h12, 0, 0, 0, 0); chk("R9 LOP over TIM", out_z7, 5);
        chk("R10 V5 bit8 follows Z7 bit5", out_rdi, 1);

        // R10: enhanced sources; R2 field [10:8]
        wcfg(12, 12'h3C0);
        svc(12, 1, 5'h01, 0, 0, 0, 0);
        chk("R10 manual code", out_z7, 3);
        chk("R10 V5 bit8 manual", out_rdi, 0);
        wcfg(12, 12'h041);
        svc(12, 1, 5'h01, 0, 0, 0, 6'h20);
        chk("R10 ring code", out_z7, 4);
        chk("R10 V5 bit8 ring", out_rdi, 1);

        // R2: write applies from next cycle, other channels untouched
        svc(13, 1, 5'h01, 0, 0, 0, 0);
        chk("R2 untouched channel one-bit", out_z7, 0);

        // R1: illegal indices ignored
        wcfg(0, 12'hFFF);
        wcfg(29, 12'hFFF);
        wcfg(31, 12'hFFF);
        svc(29, 1, 5'h1F, 1, 1, 1, 6'h3F);
        chk("R1 ch29 no strobe", out_vld, 0);
        svc(0, 1, 5'h1F, 1, 1, 1, 6'h3F);
        chk("R1 ch0 no strobe", out_vld, 0);
        svc(28, 1, 0, 0, 0, 0, 0);
        chk("R1 ch28 valid", out_vld, 1);
        chk("R1 ch28 config untouched", out_z7, 0);

        // R11: mid-multiframe activity holds outputs
        svc(12, 0, 5'h1F, 1, 1, 1, 6'h3F);
        chk("R11 hold rfi", out_rfi, 0);
        chk("R11 no strobe", out_vld, 0);

        // mixed traffic
        for (int n = 0; n < 4000; n++) begin
            idle();
            if ($urandom_range(7) == 0) begin
                cfg_we = 1; cfg_ch = 5'($urandom_range(31)); cfg_wdata = 12'($urandom);
            end
            if ($urandom_range(3) != 0) begin
                svc_vld = 1; svc_ch = 5'($urandom_range(31));
                svc_mf = ($urandom_range(3) == 0);
                svc_def = ($urandom_range(1) == 0) ? 5'($urandom) : 5'h00;
                svc_auto_ais = ($urandom_range(7) == 0);
                svc_rai = $urandom_range(1);
                svc_bip_err = ($urandom_range(5) == 0);
                svc_rx_oh = 6'($urandom);
            end
            tick();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule